// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the three-wire programming port of a frequency synthesizer. An external controller drives a serial clock, a data line and a load strobe. The port runs on the system clock, so all three inputs pass through a synchroniser first. Each synchronised rising edge of the serial clock shifts one data bit into a 19-bit word.

When the load strobe rises, the final bit that was shifted in acts as a steering bit. It sends the word to one of two holding groups. The reference group holds a 14-bit reference divide ratio and four single-bit mode selects: prescaler modulus, phase polarity, monitor output choice and pump current. The feedback group holds a 7-bit swallow count and an 11-bit programmable count.

The latched fields drive the divider and comparator logic directly. A sticky flag reports a prohibited setting that has been loaded.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, every latched field (reference ratio, the four mode selects, swallow count, programmable count) reads zero and the error flag is low.
- R2: Each synchronised rising edge of the serial clock shifts the data line into the word's least significant end. Data goes in most significant bit first, so the last bit sent lands at word position 1, the steering bit. Only the last 19 bits shifted before a load count.
- R3: A load with steering bit 1 updates the reference group and leaves the feedback group unchanged. Reference ratio = word bits 2..15, with bit 2 as the LSB. Modulus select = bit 16, polarity = bit 17, monitor select = bit 18, pump current = bit 19.
- R4: A load with steering bit 0 updates the feedback group and leaves the reference group unchanged. Swallow count = word bits 2..8, with bit 2 as the LSB. Programmable count = bits 9..19, with bit 9 as the LSB.
- R5: The latched fields change only in response to a rising edge of the load strobe, and each such edge produces exactly one transfer. Shifting in a new word without a load leaves every output unchanged.
- R6: Loading a reference ratio below 3 raises the error flag. The ratio is still latched as written.
- R7: A feedback load raises the error flag if the programmable count is below 3. It also raises the flag if the swallow count is not less than the programmable count in the same word. A swallow count one below the programmable count does not raise the flag.
- R8: Once raised, the error flag stays high through later legal loads until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, transfer on rising edge |
| ref_div | output | 14 | Latched reference divide ratio |
| mod_sel | output | 1 | Prescaler modulus select |
| pol_sel | output | 1 | Phase comparator polarity select |
| mon_sel | output | 1 | Monitor output select |
| pump_sel | output | 1 | Charge-pump current select |
| swal_cnt | output | 7 | Latched swallow count |
| prog_cnt | output | 11 | Latched programmable count |
| cfg_err | output | 1 | Sticky prohibited-setting flag |

## Verification
The assertions assume that the load strobe is low whenever a synchronised serial clock rise arrives. They also assume that every input level is held for more system cycles than the synchroniser depth, so that each serial edge is seen exactly once. The stimulus holds each data, clock and strobe level for four system cycles. It raises the load strobe only after the final falling clock edge of a word and lowers it before the next word starts. The same stimulus covers the corner cases: ratios of exactly 2, a swallow count equal to the programmable count, and a swallow count one below it.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int REF_W  = 14;
    localparam int SWAL_W = 7;
    localparam int PROG_W = 11;
    localparam int MODE_W = 4;
    localparam int WORD_W = 1 + REF_W + MODE_W;

    // Packed so that word[WORD_W-1:1] maps directly onto the fields
    typedef struct packed {
        logic             pump;
        logic             mon;
        logic             pol;
        logic             modsel;
        logic [REF_W-1:0] div;
    } ref_cfg_t;

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic [SWAL_W-1:0] swal;
    } fb_cfg_t;

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_data,
    input  logic              s_load,
    output logic [WORD_W-1:0] word,
    output logic              load_pulse
);

    typedef struct packed {
        logic              clk_p;
        logic              load_p;
        logic [WORD_W-1:0] word;
        logic              pulse;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      clk_rise;

    always_comb begin
        st_d        = st_q;
        clk_rise    = s_clk & ~st_q.clk_p;
        st_d.clk_p  = s_clk;
        st_d.load_p = s_load;
        st_d.pulse  = s_load & ~st_q.load_p;
        if (clk_rise) begin
            st_d.word = {st_q.word[WORD_W-2:0], s_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word       = st_q.word;
    assign load_pulse = st_q.pulse;

    // R5: each load strobe edge yields a single-cycle transfer request
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);

    // R2: the word moves only on a serial clock rise
    assert_shift_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_rise |=> $stable(word));

    // R2: input rule - the strobe stays low while bits are shifting
    assert_load_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |-> !s_load);

endmodule

// File: rtl/synth_cfg_latch.sv
module synth_cfg_latch
    import synth_cfg_pkg::*;
#(
    parameter int MIN_RATIO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              load_pulse,
    output ref_cfg_t          ref_cfg,
    output fb_cfg_t           fb_cfg,
    output logic              err
);

    localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
    localparam logic [PROG_W-1:0] PROG_MIN = PROG_W'(MIN_RATIO);

    typedef struct packed {
        ref_cfg_t ref_cfg;
        fb_cfg_t  fb_cfg;
        logic     err;
    } latch_st_t;

    latch_st_t st_d, st_q;
    ref_cfg_t  ref_new;
    fb_cfg_t   fb_new;
    logic      steer;

    always_comb begin
        st_d    = st_q;
        steer   = word[0];
        ref_new = ref_cfg_t'(word[WORD_W-1:1]);
        fb_new  = fb_cfg_t'(word[WORD_W-1:1]);
        if (load_pulse) begin
            if (steer) begin
                st_d.ref_cfg = ref_new;
                if (ref_new.div < REF_MIN) st_d.err = 1'b1;
            end else begin
                st_d.fb_cfg = fb_new;
                if (fb_new.prog < PROG_MIN) st_d.err = 1'b1;
                if (PROG_W'(fb_new.swal) >= fb_new.prog) st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_cfg = st_q.ref_cfg;
    assign fb_cfg  = st_q.fb_cfg;
    assign err     = st_q.err;

    // R8: the error flag never falls outside reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R5: no transfer request, no change in either group
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> ($stable(ref_cfg) && $stable(fb_cfg)));

    // R3 / R4: one transfer touches at most one group
    assert_one_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> ($stable(ref_cfg) || $stable(fb_cfg)));

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RATIO   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic [REF_W-1:0]  ref_div,
    output logic              mod_sel,
    output logic              pol_sel,
    output logic              mon_sel,
    output logic              pump_sel,
    output logic [SWAL_W-1:0] swal_cnt,
    output logic [PROG_W-1:0] prog_cnt,
    output logic              cfg_err
);

    logic [2:0]        sync_out;
    logic [WORD_W-1:0] word;
    logic              load_pulse;
    ref_cfg_t          ref_cfg;
    fb_cfg_t           fb_cfg;

    synth_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_load, ser_data, ser_clk}),
        .dout  (sync_out)
    );

    synth_cfg_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_clk      (sync_out[0]),
        .s_data     (sync_out[1]),
        .s_load     (sync_out[2]),
        .word       (word),
        .load_pulse (load_pulse)
    );

    synth_cfg_latch #(.MIN_RATIO(MIN_RATIO)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word),
        .load_pulse (load_pulse),
        .ref_cfg    (ref_cfg),
        .fb_cfg     (fb_cfg),
        .err        (cfg_err)
    );

    assign ref_div  = ref_cfg.div;
    assign mod_sel  = ref_cfg.modsel;
    assign pol_sel  = ref_cfg.pol;
    assign mon_sel  = ref_cfg.mon;
    assign pump_sel = ref_cfg.pump;
    assign swal_cnt = fb_cfg.swal;
    assign prog_cnt = fb_cfg.prog;

endmodule

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b0;
    logic [13:0] ref_div;
    logic        mod_sel, pol_sel, mon_sel, pump_sel;
    logic [6:0]  swal_cnt;
    logic [10:0] prog_cnt;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    synth_cfg_port u_synth_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_div(ref_div), .mod_sel(mod_sel),
        .pol_sel(pol_sel), .mon_sel(mon_sel), .pump_sel(pump_sel),
        .swal_cnt(swal_cnt), .prog_cnt(prog_cnt), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic shift_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) begin
            ser_data = w[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(4);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        wait_cyc(4);
        ser_load = 1'b0;
        wait_cyc(8);
    endtask

    function automatic logic [18:0] ref_word(input logic [13:0] r, input logic sw,
                                             input logic fc, input logic lds, input logic cs);
        return {cs, lds, fc, sw, r, 1'b1};
    endfunction

    function automatic logic [18:0] fb_word(input logic [6:0] a, input logic [10:0] n);
        return {n, a, 1'b0};
    endfunction

    task automatic t_reset();
        chk("R1 ref_div", ref_div, 0);
        chk("R1 modes", {mod_sel, pol_sel, mon_sel, pump_sel}, 0);
        chk("R1 swal_cnt", swal_cnt, 0);
        chk("R1 prog_cnt", prog_cnt, 0);
        chk("R1 cfg_err", cfg_err, 0);
    endtask

    task automatic t_ref_load();
        shift_word(ref_word(14'd1234, 1'b1, 1'b0, 1'b1, 1'b0));
        pulse_load();
        chk("R3 ref_div", ref_div, 1234);
        chk("R3 modes sw,fc,lds,cs", {mod_sel, pol_sel, mon_sel, pump_sel}, 4'b1010);
        chk("R3 feedback untouched", {swal_cnt, prog_cnt}, 0);
        chk("R3 cfg_err", cfg_err, 0);
        shift_word(ref_word(14'h2A55, 1'b0, 1'b1, 1'b0, 1'b1));
        pulse_load();
        chk("R3 ref_div pattern2", ref_div, 14'h2A55);
        chk("R3 modes pattern2", {mod_sel, pol_sel, mon_sel, pump_sel}, 4'b0101);
    endtask

    task automatic t_fb_load();
        shift_word(fb_word(7'd5, 11'd100));
        pulse_load();
        chk("R4 swal_cnt", swal_cnt, 5);
        chk("R4 prog_cnt", prog_cnt, 100);
        chk("R4 reference untouched", ref_div, 14'h2A55);
        chk("R4 cfg_err", cfg_err, 0);
        shift_word(fb_word(7'd127, 11'd2047));
        pulse_load();
        chk("R4 swal_cnt max", swal_cnt, 127);
        chk("R4 prog_cnt max", prog_cnt, 2047);
    endtask

    task automatic t_no_load_window();
        // two words back to back, no strobe: outputs hold
        shift_word(ref_word(14'd7, 1'b1, 1'b1, 1'b1, 1'b1));
        shift_word(fb_word(7'd33, 11'd777));
        chk("R5 ref_div held", ref_div, 14'h2A55);
        chk("R5 prog_cnt held", prog_cnt, 2047);
        pulse_load();
        chk("R2 last word wins swal", swal_cnt, 33);
        chk("R2 last word wins prog", prog_cnt, 777);
        chk("R2 reference not loaded", ref_div, 14'h2A55);
    endtask

    task automatic t_ref_err();
        do_reset();
        shift_word(ref_word(14'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        pulse_load();
        chk("R6 ratio 3 legal", cfg_err, 0);
        shift_word(ref_word(14'd2, 1'b0, 1'b0, 1'b0, 1'b0));
        pulse_load();
        chk("R6 ratio 2 flags", cfg_err, 1);
        chk("R6 ratio still latched", ref_div, 2);
        shift_word(fb_word(7'd1, 11'd50));
        pulse_load();
        chk("R8 flag stays", cfg_err, 1);
        chk("R8 legal load applied", prog_cnt, 50);
    endtask

    task automatic t_fb_err();
        do_reset();
        chk("R1 err cleared by reset", cfg_err, 0);
        shift_word(fb_word(7'd9, 11'd10));
        pulse_load();
        chk("R7 swallow one below", cfg_err, 0);
        shift_word(fb_word(7'd10, 11'd10));
        pulse_load();
        chk("R7 swallow equal", cfg_err, 1);
        do_reset();
        shift_word(fb_word(7'd0, 11'd2));
        pulse_load();
        chk("R7 count 2 flags", cfg_err, 1);
        chk("R7 count latched", prog_cnt, 2);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ref_load();
        t_fb_load();
        t_no_load_window();
        t_ref_err();
        t_fb_err();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule